// File: doc/BRIEF.md
# Extended State Save/Restore Sequencer

This block moves two pieces of processor state between an internal register file and a fixed memory image, one 128-bit word per beat. The two pieces are the floating-point environment with its eight stack registers, and the vector register set with its control/status word. A request names a 64-byte aligned base address, a direction (save or restore) and a two-bit component mask. A component takes part only when the mask and the feature-enable input both select it. A 64-bit header at byte offset 512 of the image records which components hold valid data.

On save, the sequencer reads the header first. It then copies each active component out of the register file. Last, it writes the header back with the bit of each saved component set. On restore, it reads and checks the header words. A component whose header bit is clear is written with reset values instead of being loaded. A bad header, a misaligned base, or a vector control/status value with unsupported bits raises a fault pulse together with the done pulse. The register file index equals the image word index (byte offset / 16), so word 0 is the floating-point environment, word 1 holds the data pointer and the vector control word, words 2..9 are the stack registers and words 10 and up are the vector registers.

Top module: `xstate_seq`

## Requirements
- R1: A request whose base address has any of bits 5:0 set produces fault and done one cycle after start and issues no memory request.
- R2: Component 0 (floating point) is active when bit 0 of both feat_en and req_mask is 1; component 1 (vector) is active when bit 1 of both is 1. An inactive component's image words and register-file words are left unchanged.
- R3: A save first reads image word 32 (byte 512), and as its final beat writes that word with byte enable 16'h00FF. The written header is the old low qword OR-ed with bit 0 if floating point was saved and bit 1 if vector was saved. This final write happens even when no component is active.
- R4: Save layout: word 0 is register 0 as is. Word 1 bytes 0..7 are register 1 bits 63:0, written only for floating point. Word 1 bytes 8..11 are register 1 bits 95:64 and bytes 12..15 are the VCSR_MASK parameter, written only for vector. Words 2..9 carry register bits 79:0 with the upper 48 bits zero. Vector register i goes to word 10+i.
- R5: Vector registers 8..15 (words 18..25) are transferred or reset only when long_mode is 1.
- R6: A restore reads words 32 and 33. It faults with no register-file write if header bits 63:0 have a bit not set in feat_en, if header bits 127:64 are nonzero, or if word 33 bits 63:0 are nonzero.
- R7: With vector active, a restore faults when word 1 bits 95:64 have a bit outside VCSR_MASK, and that field is then left unwritten. Otherwise the field is loaded into register 1 bits 95:64 whatever the vector header bit is.
- R8: On restore, an active component whose header bit (bit 0 floating point, bit 1 vector) is clear gets reset values. Stack and vector registers become zero, register 1 bits 63:0 become zero, and register 0 becomes 128'h037F (control word 16'h037F, all else zero).
- R9: A floating-point restore loads word 0 with bits 63:59 (upper opcode bits) cleared. Stack words are loaded with bits 127:80 cleared. Register 1 bits 63:0 are loaded from word 1.
- R10: In restored register 0, status bits 31 and 23 (busy and error summary) are set when (bits 21:16 AND NOT bits 5:0) is nonzero, and cleared otherwise.
- R11: Memory requests stay valid with a stable address until accepted. Data-word accesses are strictly ascending. Done follows the final beat, and nothing is requested or written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken while idle |
| restore | input | 1 | 1 = restore, 0 = save |
| base_addr | input | ADDR_W | Image base byte address |
| req_mask | input | 2 | Per-request component mask |
| feat_en | input | 2 | Feature-enable register value |
| long_mode | input | 1 | Selects all 16 vector registers |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | General-protection fault, with done |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 16 | Write byte enables |
| mem_wdata | output | 128 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 128 | Read data |
| rf_raddr | output | 6 | Register-file read index |
| rf_rdata | input | 128 | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write |
| rf_waddr | output | 6 | Register-file write index |
| rf_be | output | 16 | Register-file byte enables |
| rf_wdata | output | 128 | Register-file write data |

## Verification
The assertions take for granted that the register-file read port answers in the same cycle. They also assume that mem_ready is meaningful only while mem_valid is high, and that start arrives only while busy is low. The request-hold property assumes the memory never withdraws a pending beat. The bench raises start only after the previous done and drives mem_ready at random on every falling edge. It picks only 64-byte aligned bases except in the misaligned case, and keeps the image inside a 34-word window that its memory model decodes.

// File: rtl/xstate_seq.sv
module xstate_seq #(
  parameter int          ADDR_W    = 32,
  parameter int          NVEC      = 16,
  parameter logic [31:0] VCSR_MASK = 32'h0000_FFBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              restore,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        req_mask,
  input  logic [1:0]        feat_en,
  input  logic              long_mode,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_be,
  output logic [127:0]      mem_wdata,
  input  logic              mem_ready,
  input  logic [127:0]      mem_rdata,
  output logic [5:0]        rf_raddr,
  input  logic [127:0]      rf_rdata,
  output logic              rf_we,
  output logic [5:0]        rf_waddr,
  output logic [15:0]       rf_be,
  output logic [127:0]      rf_wdata
);
  localparam int         STK_BASE = 2;
  localparam int         NSTK     = 8;
  localparam int         VEC_BASE = STK_BASE + NSTK;
  localparam logic [5:0] STK_LO   = 6'(STK_BASE);
  localparam logic [5:0] VEC_LO   = 6'(VEC_BASE);
  localparam logic [5:0] VEC_FULL = 6'(VEC_BASE + NVEC);
  localparam logic [5:0] VEC_HALF = 6'(VEC_BASE + NVEC / 2);
  localparam logic [5:0] LAST     = 6'(VEC_BASE + NVEC - 1);
  localparam logic [5:0] HDR      = 6'd32;
  localparam logic [15:0] CW_INIT = 16'h037F;

  typedef enum logic [2:0] {S_IDLE, S_HRD, S_HRD2, S_WALK, S_HWR} st_t;

  st_t         st;
  logic        op_r, fpa, vca, lm_r;
  logic [1:0]  fe_r;
  logic [ADDR_W-1:0] base_r;
  logic [63:0] hdr_r;
  logic        hdr_hi_nz;
  logic [5:0]  k;

  logic is_env, is_misc, is_stk, is_vec, fp_here, vec_here, ld, walk;
  logic vbad, vfault, hfault, step;
  logic [5:0] vec_end;

  assign vec_end  = lm_r ? VEC_FULL : VEC_HALF;
  assign is_env   = (k == 6'd0);
  assign is_misc  = (k == 6'd1);
  assign is_stk   = (k >= STK_LO) && (k < VEC_LO);
  assign is_vec   = (k >= VEC_LO) && (k < vec_end);
  assign fp_here  = fpa & (is_env | is_misc | is_stk);
  assign vec_here = vca & (is_misc | is_vec);
  assign ld = op_r ? ((fp_here & hdr_r[0]) | (vca & is_misc) | (vca & is_vec & hdr_r[1]))
                   : (fp_here | vec_here);
  assign walk = (st == S_WALK);

  assign vbad   = |(mem_rdata[95:64] & ~VCSR_MASK);
  assign vfault = walk & op_r & is_misc & vca & mem_ready & vbad;
  assign hfault = (|(hdr_r & ~{62'b0, fe_r})) | hdr_hi_nz | (|mem_rdata[63:0]);
  assign step   = walk & (~ld | mem_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_r <= 1'b0; fpa <= 1'b0; vca <= 1'b0; lm_r <= 1'b0;
      fe_r <= '0; base_r <= '0; hdr_r <= '0; hdr_hi_nz <= 1'b0; k <= '0;
      done <= 1'b0; fault <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (|base_addr[5:0]) begin
            done <= 1'b1; fault <= 1'b1;
          end else begin
            op_r <= restore; lm_r <= long_mode; fe_r <= feat_en; base_r <= base_addr;
            fpa <= feat_en[0] & req_mask[0];
            vca <= feat_en[1] & req_mask[1];
            k <= HDR; st <= S_HRD;
          end
        end
        S_HRD: if (mem_ready) begin
          hdr_r <= mem_rdata[63:0];
          hdr_hi_nz <= |mem_rdata[127:64];
          if (op_r) begin k <= HDR + 6'd1; st <= S_HRD2; end
          else begin k <= '0; st <= S_WALK; end
        end
        S_HRD2: if (mem_ready) begin
          if (hfault) begin done <= 1'b1; fault <= 1'b1; st <= S_IDLE; end
          else begin k <= '0; st <= S_WALK; end
        end
        S_WALK: begin
          if (vfault) begin
            done <= 1'b1; fault <= 1'b1; st <= S_IDLE;
          end else if (step) begin
            if (k == LAST) begin
              if (op_r) begin done <= 1'b1; st <= S_IDLE; end
              else begin k <= HDR; st <= S_HWR; end
            end else k <= k + 6'd1;
          end
        end
        S_HWR: if (mem_ready) begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_valid = (st == S_HRD) | (st == S_HRD2) | (st == S_HWR) | (walk & ld);
  assign mem_we    = (st == S_HWR) | (walk & ~op_r);
  assign mem_addr  = base_r + ADDR_W'({k, 4'b0});
  assign mem_be    = (st == S_HWR) ? 16'h00FF :
                     (walk & ~op_r & is_misc) ? {{8{vca}}, {8{fpa}}} : 16'hFFFF;

  always_comb begin
    if (st == S_HWR)  mem_wdata = {64'b0, hdr_r | {62'b0, vca, fpa}};
    else if (is_misc) mem_wdata = {VCSR_MASK, rf_rdata[95:0]};
    else if (is_stk)  mem_wdata = {48'b0, rf_rdata[79:0]};
    else              mem_wdata = rf_rdata;
  end

  logic [15:0]  r_cw, r_sw;
  logic         pend;
  logic [127:0] env_fix;
  assign r_cw    = mem_rdata[15:0];
  assign r_sw    = mem_rdata[31:16];
  assign pend    = |(r_sw[5:0] & ~r_cw[5:0]);
  assign env_fix = {mem_rdata[127:64], 5'b0, mem_rdata[58:48], mem_rdata[47:32],
                    pend, r_sw[14:8], pend, r_sw[6:0], r_cw};

  assign rf_raddr = k;
  assign rf_waddr = k;
  assign rf_we    = walk & op_r & ((ld & mem_ready) | (~ld & (fp_here | vec_here)));
  assign rf_be    = is_misc ? {4'b0, {4{vca & ~vbad}}, {8{fpa}}} : 16'hFFFF;

  always_comb begin
    if (is_env)       rf_wdata = ld ? env_fix : {112'b0, CW_INIT};
    else if (is_misc) rf_wdata = {32'b0, mem_rdata[95:64], hdr_r[0] ? mem_rdata[63:0] : 64'b0};
    else if (is_stk)  rf_wdata = ld ? {48'b0, mem_rdata[79:0]} : 128'b0;
    else              rf_wdata = ld ? mem_rdata : 128'b0;
  end
endmodule

module xstate_seq_chk #(parameter int ADDR_W = 32) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] base_addr,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rf_we
);
  AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && base_addr[5:0] != 6'd0) |=> (fault && done && !busy)); // R1
  AST_MISALIGN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && base_addr[5:0] != 6'd0) |=> !mem_valid); // R1
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !rf_we)); // R11
  AST_DONE_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
endmodule

bind xstate_seq xstate_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_xstate_seq.sv
module tb_xstate_seq;
  localparam int AW = 32;
  localparam logic [31:0] VM = 32'h0000_FFBF;

  logic clk, rst_n, start, restore, long_mode, busy, done, fault;
  logic [AW-1:0] base_addr, mem_addr, cur_base, off;
  logic [1:0] req_mask, feat_en;
  logic mem_valid, mem_we, mem_ready, rf_we;
  logic [15:0] mem_be, rf_be;
  logic [127:0] mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [5:0] rf_raddr, rf_waddr, widx;

  logic [127:0] mem [0:33];
  logic [127:0] rf  [0:25];
  logic [127:0] mem0 [0:33];
  logic [127:0] rf0  [0:25];
  int seq [0:4095];
  int nseq, rfw_cnt, checks, fails;

  xstate_seq dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign off       = mem_addr - cur_base;
  assign widx      = off[9:4];
  assign mem_rdata = (off[AW-1:10] == '0 && widx < 6'd34) ? mem[widx] : '0;
  assign rf_rdata  = (rf_raddr < 6'd26) ? rf[rf_raddr] : '0;

  always @(negedge clk) mem_ready = ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (nseq < 4096) seq[nseq] = int'(widx);
      nseq = nseq + 1;
      if (mem_we && widx < 6'd34)
        for (int b = 0; b < 16; b++) if (mem_be[b]) mem[widx][8*b +: 8] = mem_wdata[8*b +: 8];
    end
    if (rf_we && rf_waddr < 6'd26) begin
      for (int b = 0; b < 16; b++) if (rf_be[b]) rf[rf_waddr][8*b +: 8] = rf_wdata[8*b +: 8];
      rfw_cnt = rfw_cnt + 1;
    end
  end

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] env_exp(logic [127:0] d);
    logic [15:0] cw, sw;
    bit p;
    cw = d[15:0]; sw = d[31:16];
    p = (sw[5:0] & ~cw[5:0]) != 6'd0;
    sw[15] = p; sw[7] = p;
    return {d[127:64], 5'b0, d[58:48], d[47:32], sw, cw};
  endfunction

  function automatic logic [127:0] exp_save(int k, logic [127:0] o, logic [127:0] r,
                                            bit fpa, bit vca, bit lm);
    logic [127:0] e = o;
    if (k == 0 && fpa) e = r;
    if (k == 1) begin
      if (fpa) e[63:0] = r[63:0];
      if (vca) e[127:64] = {VM, r[95:64]};
    end
    if (k >= 2 && k < 10 && fpa) e = {48'b0, r[79:0]};
    if (k >= 10 && k < 10 + (lm ? 16 : 8) && vca) e = r;
    return e;
  endfunction

  function automatic logic [127:0] exp_rest(int k, logic [127:0] o, logic [127:0] m,
                                            logic [1:0] h, bit fpa, bit vca, bit lm);
    logic [127:0] e = o;
    if (k == 0 && fpa) e = h[0] ? env_exp(m) : 128'h037F;
    if (k == 1) begin
      if (fpa) e[63:0] = h[0] ? m[63:0] : 64'b0;
      if (vca) e[95:64] = m[95:64];
    end
    if (k >= 2 && k < 10 && fpa) e = h[0] ? {48'b0, m[79:0]} : 128'b0;
    if (k >= 10 && k < 10 + (lm ? 16 : 8) && vca) e = h[1] ? m : 128'b0;
    return e;
  endfunction

  task automatic run_op(input bit rs, input logic [AW-1:0] b, input logic [1:0] m,
                        input logic [1:0] fe, input bit lm, output bit flt, output int s0);
    int n;
    for (int i = 0; i < 34; i++) mem0[i] = mem[i];
    for (int i = 0; i < 26; i++) rf0[i] = rf[i];
    @(negedge clk);
    cur_base = b; restore = rs; base_addr = b; req_mask = m; feat_en = fe; long_mode = lm;
    start = 1'b1; s0 = nseq;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (!done) chk(1'b0, "R11", "watchdog expired", 128'(n), 128'd0);
    flt = fault;
  endtask

  task automatic check_order(input int s0, input bit rs, input string tag);
    bit ok = 1'b1;
    int last = -1;
    int e = nseq;
    if (e - s0 < 2 || seq[s0] != 32) ok = 1'b0;
    if (rs && seq[s0 + 1] != 33) ok = 1'b0;
    if (!rs && seq[e - 1] != 32) ok = 1'b0;
    for (int i = s0; i < e; i++)
      if (seq[i] < 32) begin
        if (seq[i] <= last) ok = 1'b0;
        last = seq[i];
      end
    chk(ok, tag, "beat order", 128'(seq[s0]), 128'd32);
  endtask

  task automatic verify_save(input bit fpa, input bit vca, input bit lm, input string tag);
    bit ok = 1'b1;
    logic [127:0] a = '0, x = '0, e;
    for (int k = 0; k < 34; k++) begin
      if (k < 26) e = exp_save(k, mem0[k], rf0[k], fpa, vca, lm);
      else if (k == 32) e = {mem0[32][127:64], mem0[32][63:0] | {62'b0, vca, fpa}};
      else e = mem0[k];
      if (mem[k] !== e && ok) begin ok = 1'b0; a = mem[k]; x = e; end
    end
    chk(ok, tag, "save image", a, x);
  endtask

  task automatic verify_rest(input bit fpa, input bit vca, input bit lm, input string tag);
    bit ok = 1'b1;
    logic [127:0] a = '0, x = '0, e;
    for (int k = 0; k < 26; k++) begin
      e = exp_rest(k, rf0[k], mem0[k], mem0[32][1:0], fpa, vca, lm);
      if (rf[k] !== e && ok) begin ok = 1'b0; a = rf[k]; x = e; end
    end
    chk(ok, tag, "restored registers", a, x);
  endtask

  task automatic rf_same(input string tag);
    bit ok = 1'b1;
    for (int k = 0; k < 26; k++) if (rf[k] !== rf0[k]) ok = 1'b0;
    chk(ok, tag, "register file unchanged", 128'(ok), 128'd1);
  endtask

  task automatic fill_rest(input logic [1:0] h);
    for (int i = 0; i < 34; i++) mem[i] = r128();
    mem[1][95:64] = mem[1][95:64] & VM;
    mem[32] = {64'b0, 62'b0, h};
    mem[33][63:0] = 64'b0;
  endtask

  initial begin
    bit flt;
    int s0, w0;
    logic [AW-1:0] b;
    logic [1:0] m, fe;
    bit lm, rs;
    void'($urandom(32'd20240611));
    checks = 0; fails = 0; nseq = 0; rfw_cnt = 0; cur_base = '0;
    start = 0; restore = 0; base_addr = '0; req_mask = '0; feat_en = '0; long_mode = 0;
    mem_ready = 0;
    for (int i = 0; i < 34; i++) mem[i] = r128();
    for (int i = 0; i < 26; i++) rf[i] = r128();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_valid && !rf_we, "R11", "reset state",
        {busy, done, fault, mem_valid, rf_we}, 128'd0);
    rst_n = 1;

    // R1: misaligned base
    w0 = nseq;
    run_op(1'b0, 32'h0000_1008, 2'b11, 2'b11, 1'b1, flt, s0);
    chk(flt && nseq == w0, "R1", "misaligned save faults without beats", 128'(nseq - w0), 128'd0);
    w0 = rfw_cnt;
    run_op(1'b1, 32'h0000_2021, 2'b11, 2'b11, 1'b1, flt, s0);
    chk(flt && rfw_cnt == w0, "R1", "misaligned restore faults", 128'(flt), 128'd1);

    // R3: nothing active still writes header
    run_op(1'b0, 32'h0000_4000, 2'b00, 2'b11, 1'b1, flt, s0);
    verify_save(0, 0, 1, "R3");
    chk(nseq - s0 == 2, "R3", "header read and write only", 128'(nseq - s0), 128'd2);
    check_order(s0, 1'b0, "R3");

    // R4 R5: full save, then vector only in short mode
    run_op(1'b0, 32'h0001_0000, 2'b11, 2'b11, 1'b1, flt, s0);
    verify_save(1, 1, 1, "R4");
    for (int i = 0; i < 26; i++) rf[i] = r128();
    run_op(1'b0, 32'h0001_0000, 2'b10, 2'b11, 1'b0, flt, s0);
    verify_save(0, 1, 0, "R5");
    check_order(s0, 1'b0, "R11");

    // R6: header faults
    fill_rest(2'b11); mem[32][2] = 1'b1; w0 = rfw_cnt;
    run_op(1'b1, 32'h0000_8000, 2'b11, 2'b11, 1'b1, flt, s0);
    chk(flt && rfw_cnt == w0, "R6", "unsupported header bit", 128'(flt), 128'd1);
    rf_same("R6");
    fill_rest(2'b10);
    run_op(1'b1, 32'h0000_8000, 2'b11, 2'b01, 1'b1, flt, s0);
    chk(flt, "R6", "header bit not enabled", 128'(flt), 128'd1);
    fill_rest(2'b01); mem[32][100] = 1'b1;
    run_op(1'b1, 32'h0000_8000, 2'b11, 2'b11, 1'b1, flt, s0);
    chk(flt, "R6", "second header qword nonzero", 128'(flt), 128'd1);
    fill_rest(2'b01); mem[33][5] = 1'b1;
    run_op(1'b1, 32'h0000_8000, 2'b11, 2'b11, 1'b1, flt, s0);
    chk(flt, "R6", "third header qword nonzero", 128'(flt), 128'd1);

    // R7: invalid vector control word
    fill_rest(2'b11); mem[1][95:64] = 32'h0001_0000;
    run_op(1'b1, 32'h0000_8000, 2'b10, 2'b11, 1'b1, flt, s0);
    chk(flt && rf[1][95:64] === rf0[1][95:64], "R7", "bad control word faults",
        rf[1], rf0[1]);

    // R8 R7: headers clear, reset values, control word still loaded
    fill_rest(2'b00);
    run_op(1'b1, 32'h0000_8000, 2'b11, 2'b11, 1'b1, flt, s0);
    chk(!flt, "R8", "no fault", 128'(flt), 128'd0);
    verify_rest(1, 1, 1, "R8");
    chk(rf[1][95:64] === mem[1][95:64], "R7", "control word loaded", rf[1], mem[1]);

    // R9 R10: opcode masking and status summary
    fill_rest(2'b01);
    mem[0][63:48] = 16'hFFFF; mem[0][15:0] = 16'h0000; mem[0][31:16] = 16'h0001;
    run_op(1'b1, 32'h0000_8000, 2'b01, 2'b01, 1'b0, flt, s0);
    chk(rf[0][63:48] == 16'h07FF, "R9", "opcode upper bits cleared", rf[0], mem[0]);
    chk(rf[0][31] && rf[0][23], "R10", "summary set when unmasked", rf[0], mem[0]);
    check_order(s0, 1'b1, "R11");
    fill_rest(2'b01);
    mem[0][15:0] = 16'h003F; mem[0][31:16] = 16'h80BF;
    run_op(1'b1, 32'h0000_8000, 2'b01, 2'b11, 1'b1, flt, s0);
    chk(!rf[0][31] && !rf[0][23], "R10", "summary cleared when masked", rf[0], mem[0]);

    // R2: random mixes
    for (int it = 0; it < 40; it++) begin
      b = {10'b0, 16'($urandom), 6'b0};
      m = 2'($urandom); fe = 2'($urandom); lm = 1'($urandom); rs = 1'($urandom);
      if (rs) begin
        fill_rest(2'($urandom) & fe);
        run_op(1'b1, b, m, fe, lm, flt, s0);
        chk(!flt, "R2", "random restore fault", 128'(flt), 128'd0);
        verify_rest(m[0] & fe[0], m[1] & fe[1], lm, "R2");
      end else begin
        for (int i = 0; i < 26; i++) rf[i] = r128();
        run_op(1'b0, b, m, fe, lm, flt, s0);
        verify_save(m[0] & fe[0], m[1] & fe[1], lm, "R2");
      end
      check_order(s0, rs, "R11");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule